// File: doc/BRIEF.md
# Decode-Stage Branch Resolver with Cancelling Slot

This unit decides, while a conditional branch sits in decode, where fetch goes next. It tests one already-forwarded register for zero or non-zero and adds the sign-extended 16-bit displacement to the incremented PC of the branch. It then drives a next-PC select, the target address and a squash line that turns the instruction in the fetch/decode buffer into a no-op in that same cycle. Resolving in decode costs one cycle per branch, where resolving in a later stage would cost three.

A mode input picks one of two policies. In flush mode, fetch runs on sequentially and the sequential instruction is flushed whenever the branch is taken. In cancelling mode, the instruction after the branch always enters the pipeline as a delay slot. The branch carries a static direction hint, and the slot is squashed only when the actual outcome differs from that hint.

When the branch register is still being produced by the instruction in execute, the unit stalls decode for exactly one cycle and then resolves. The forwarded operand it uses is the one present on that second cycle.

The control is a two-state machine:
- `ST_READY`: resolve or stall.
- `ST_HOLD`: the one waiting cycle.

Its transitions:
- `READY->HOLD`: a valid branch with an operand hazard.
- `HOLD->READY`: always.
- `READY->READY`: every other case.

Top module: `brc_unit`

## Requirements
- R1: After reset the machine is in `ST_READY`. With no branch presented, `nxt_pc_sel`, `slot_squash` and `dec_stall` are 0. A reset applied while in `ST_HOLD` returns the machine to `ST_READY`, so a following hazard branch stalls again.
- R2: `br_target` equals `pc_inc` plus the 16-bit displacement sign-extended to 32 bits, wrapping modulo 2^32, for both positive and negative displacements.
- R3: Kind `2'b01` is taken when the operand equals zero. Kind `2'b10` is taken when the operand is non-zero. A resolved taken branch drives `nxt_pc_sel` = 1, and a resolved not-taken branch drives it to 0.
- R4: Kind `2'b00`, reserved kind `2'b11`, and `dec_valid` = 0 each give `nxt_pc_sel` = 0, `slot_squash` = 0 and `dec_stall` = 0, whatever the operand.
- R5: In flush mode (`cancel_mode` = 0), `slot_squash` is 1 exactly when a resolved branch is taken. The hint bit has no effect.
- R6: In cancelling mode (`cancel_mode` = 1), `slot_squash` is 1 exactly when the resolved outcome differs from `hint_taken`. `nxt_pc_sel` still follows the actual outcome.
- R7: A valid branch with `opnd_hazard` = 1 in `ST_READY` drives `dec_stall` = 1 and holds `nxt_pc_sel` and `slot_squash` at 0 in that cycle.
- R8: In `ST_HOLD` the branch resolves on the current operand, whatever `opnd_hazard` is. `dec_stall` is never 1 in two consecutive cycles.
- R9: `nxt_pc_sel`, `slot_squash` and `br_target` respond in the same cycle the branch is presented, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cancel_mode | input | 1 | 0 = flush policy, 1 = cancelling delay slot |
| dec_valid | input | 1 | Decode holds a valid instruction |
| br_kind | input | 2 | 00 none, 01 branch-if-zero, 10 branch-if-nonzero, 11 reserved |
| hint_taken | input | 1 | Static predicted direction encoded in the branch |
| opnd_hazard | input | 1 | Branch register is produced by the instruction in execute |
| opnd_val | input | 32 | Forwarded branch register value |
| disp16 | input | 16 | Branch displacement, signed |
| pc_inc | input | 32 | PC of the branch plus 4 |
| nxt_pc_sel | output | 1 | 1 = fetch from br_target, 0 = sequential |
| br_target | output | 32 | Taken target address |
| slot_squash | output | 1 | Turn the fetch/decode buffer entry into a no-op |
| dec_stall | output | 1 | Hold decode this cycle |

## Verification
Only the hold state is internal. If the machine stuck in `ST_HOLD` or never left it, the next hazard branch would resolve at once instead of stalling. That shows on `dec_stall` and `nxt_pc_sel` in the first cycle of that branch. If the machine entered `ST_HOLD` when it should not, the stall would be missing or doubled, which shows on `dec_stall` in the following cycle. Outcome and policy errors appear on `nxt_pc_sel` and `slot_squash` in the cycle the branch is presented, because those paths are combinational.

// File: rtl/brc_pkg.sv
package brc_pkg;
    typedef enum logic [1:0] {
        BK_NONE = 2'b00,
        BK_EQZ  = 2'b01,
        BK_NEZ  = 2'b10,
        BK_RSVD = 2'b11
    } br_kind_e;

    typedef enum logic {
        ST_READY = 1'b0,
        ST_HOLD  = 1'b1
    } res_state_e;
endpackage

// File: rtl/brc_cond_eval.sv
module brc_cond_eval
    import brc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [1:0]      kind,
    input  logic [XLEN-1:0] opnd,
    output logic            is_branch,
    output logic            taken
);
    br_kind_e kind_e;
    logic     opnd_zero;

    assign kind_e    = br_kind_e'(kind);
    assign opnd_zero = (opnd == '0);

    always_comb begin
        is_branch = 1'b0;
        taken     = 1'b0;
        unique case (kind_e)
            BK_EQZ: begin
                is_branch = 1'b1;
                taken     = opnd_zero;
            end
            BK_NEZ: begin
                is_branch = 1'b1;
                taken     = !opnd_zero;
            end
            BK_NONE, BK_RSVD: begin
                is_branch = 1'b0;
                taken     = 1'b0;
            end
            default: begin
                is_branch = 1'b0;
                taken     = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/brc_target_add.sv
module brc_target_add #(
    parameter int XLEN = 32,
    parameter int OFFW = 16
) (
    input  logic [XLEN-1:0] pc_inc,
    input  logic [OFFW-1:0] disp,
    output logic [XLEN-1:0] target
);
    localparam int EXTW = XLEN - OFFW;

    logic [XLEN-1:0] disp_ext;

    generate
        if (EXTW > 0) begin : g_sext
            assign disp_ext = {{EXTW{disp[OFFW-1]}}, disp};
        end else begin : g_direct
            assign disp_ext = disp[XLEN-1:0];
        end
    endgenerate

    assign target = pc_inc + disp_ext;
endmodule

// File: rtl/brc_ctrl_fsm.sv
module brc_ctrl_fsm
    import brc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cancel_mode,
    input  logic dec_valid,
    input  logic is_branch,
    input  logic taken,
    input  logic hint_taken,
    input  logic opnd_hazard,
    output logic pc_sel,
    output logic squash,
    output logic stall
);
    res_state_e state_q, state_d;
    logic       br_live;

    assign br_live = dec_valid && is_branch;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_READY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        pc_sel  = 1'b0;
        squash  = 1'b0;
        stall   = 1'b0;
        unique case (state_q)
            ST_READY: begin
                if (br_live && opnd_hazard) begin
                    stall   = 1'b1;
                    state_d = ST_HOLD;
                end else if (br_live) begin
                    pc_sel = taken;
                    squash = cancel_mode ? (taken != hint_taken) : taken;
                end
            end
            ST_HOLD: begin
                state_d = ST_READY;
                if (br_live) begin
                    pc_sel = taken;
                    squash = cancel_mode ? (taken != hint_taken) : taken;
                end
            end
            default: state_d = ST_READY;
        endcase
    end

    // R8
    hold_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);

    // R7
    stall_no_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (!pc_sel && !squash));

    // R4
    nonbranch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !br_live |-> (!pc_sel && !squash && !stall));

    // R5
    flush_on_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cancel_mode && br_live && !stall) |-> (squash == taken));

    // R6
    cancel_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cancel_mode && br_live && !stall && (taken == hint_taken)) |-> !squash);
endmodule

// File: rtl/brc_unit.sv
module brc_unit
    import brc_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int OFFW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cancel_mode,
    input  logic            dec_valid,
    input  logic [1:0]      br_kind,
    input  logic            hint_taken,
    input  logic            opnd_hazard,
    input  logic [XLEN-1:0] opnd_val,
    input  logic [OFFW-1:0] disp16,
    input  logic [XLEN-1:0] pc_inc,
    output logic            nxt_pc_sel,
    output logic [XLEN-1:0] br_target,
    output logic            slot_squash,
    output logic            dec_stall
);
    logic is_branch;
    logic taken;

    brc_cond_eval #(.XLEN(XLEN)) u_cond (
        .kind      (br_kind),
        .opnd      (opnd_val),
        .is_branch (is_branch),
        .taken     (taken)
    );

    brc_target_add #(.XLEN(XLEN), .OFFW(OFFW)) u_tadd (
        .pc_inc (pc_inc),
        .disp   (disp16),
        .target (br_target)
    );

    brc_ctrl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cancel_mode (cancel_mode),
        .dec_valid   (dec_valid),
        .is_branch   (is_branch),
        .taken       (taken),
        .hint_taken  (hint_taken),
        .opnd_hazard (opnd_hazard),
        .pc_sel      (nxt_pc_sel),
        .squash      (slot_squash),
        .stall       (dec_stall)
    );

    // R3
    sel_needs_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nxt_pc_sel |-> (dec_valid && (br_kind == 2'b01 || br_kind == 2'b10)));
endmodule

// File: tb/brc_unit_tb.sv
module brc_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cancel_mode = 1'b0;
    logic        dec_valid = 1'b0;
    logic [1:0]  br_kind = 2'b00;
    logic        hint_taken = 1'b0;
    logic        opnd_hazard = 1'b0;
    logic [31:0] opnd_val = '0;
    logic [15:0] disp16 = '0;
    logic [31:0] pc_inc = '0;
    logic        nxt_pc_sel;
    logic [31:0] br_target;
    logic        slot_squash;
    logic        dec_stall;

    int checks = 0;
    int errors = 0;
    bit prev_stall = 1'b0;
    bit done = 1'b0;

    typedef struct packed {
        logic        sel;
        logic        sq;
        logic        stl;
        logic        chk_tgt;
        logic [31:0] tgt;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    brc_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cancel_mode(cancel_mode),
        .dec_valid(dec_valid), .br_kind(br_kind), .hint_taken(hint_taken),
        .opnd_hazard(opnd_hazard), .opnd_val(opnd_val), .disp16(disp16),
        .pc_inc(pc_inc), .nxt_pc_sel(nxt_pc_sel), .br_target(br_target),
        .slot_squash(slot_squash), .dec_stall(dec_stall)
    );

    task automatic drive(input logic v, input logic [1:0] k, input logic [31:0] rs,
                         input logic [15:0] off, input logic [31:0] pc, input logic hint,
                         input logic haz, input logic mode, input string tag);
        exp_t e;
        bit   isbr, tk, res;
        @(posedge clk);
        #1;
        dec_valid = v; br_kind = k; opnd_val = rs; disp16 = off;
        pc_inc = pc; hint_taken = hint; opnd_hazard = haz; cancel_mode = mode;
        isbr = v && (k == 2'b01 || k == 2'b10);
        tk   = (k == 2'b01) ? (rs == 32'd0) : (rs != 32'd0);
        e.stl = isbr && haz && !prev_stall;
        res   = isbr && !e.stl;
        e.sel = res && tk;
        e.sq  = res && (mode ? (tk != hint) : tk);
        e.chk_tgt = isbr;
        e.tgt = pc + {{16{off[15]}}, off};
        prev_stall = e.stl;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input string tag);
        drive(1'b0, 2'b00, 32'd0, 16'd0, 32'd0, 1'b0, 1'b0, 1'b0, tag);
    endtask

    task automatic apply_reset();
        @(posedge clk);
        #1;
        rst_n = 1'b0;
        dec_valid = 1'b0; br_kind = 2'b00; opnd_hazard = 1'b0;
        prev_stall = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    always @(negedge clk) begin
        if (rst_n && exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (nxt_pc_sel !== e.sel || slot_squash !== e.sq || dec_stall !== e.stl ||
                (e.chk_tgt && br_target !== e.tgt)) begin
                errors++;
                $display("FAIL %s: sel/squash/stall/target = %0b/%0b/%0b/%h expected %0b/%0b/%0b/%h",
                         t, nxt_pc_sel, slot_squash, dec_stall, br_target,
                         e.sel, e.sq, e.stl, e.tgt);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: expected completion, got timeout");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        apply_reset();
        idle("R1 reset state");
        // R3 R5 R2 R9: flush mode, positive displacement
        drive(1, 2'b01, 32'd0, 16'h0010, 32'h0000_1004, 0, 0, 0, "R3 R5 R9 eqz taken");
        drive(1, 2'b01, 32'd5, 16'h0010, 32'h0000_1004, 1, 0, 0, "R3 R5 eqz not taken, hint ignored");
        drive(1, 2'b10, 32'd5, 16'hFFF0, 32'h0000_2000, 0, 0, 0, "R2 R3 nez taken negative disp");
        drive(1, 2'b10, 32'd0, 16'h0004, 32'h0000_2000, 1, 0, 0, "R3 nez not taken");
        drive(1, 2'b01, 32'd0, 16'h0008, 32'hFFFF_FFFC, 0, 0, 0, "R2 target wrap");
        // R4: non-branch cases
        drive(1, 2'b00, 32'd0, 16'h0008, 32'h0000_3000, 1, 1, 0, "R4 kind none");
        drive(1, 2'b11, 32'd0, 16'h0008, 32'h0000_3000, 1, 1, 1, "R4 kind reserved");
        drive(0, 2'b01, 32'd0, 16'h0008, 32'h0000_3000, 0, 1, 0, "R4 invalid decode");
        // R6: cancelling mode, all four combinations
        drive(1, 2'b01, 32'd0, 16'h0020, 32'h0000_4004, 1, 0, 1, "R6 taken hint taken");
        drive(1, 2'b01, 32'd0, 16'h0020, 32'h0000_4004, 0, 0, 1, "R6 taken hint not");
        drive(1, 2'b01, 32'd3, 16'h0020, 32'h0000_4004, 1, 0, 1, "R6 not taken hint taken");
        drive(1, 2'b01, 32'd3, 16'h0020, 32'h0000_4004, 0, 0, 1, "R6 not taken hint not");
        // R7 R8: hazard stall, then resolve on the new operand
        drive(1, 2'b01, 32'd7, 16'h0040, 32'h0000_5004, 0, 1, 0, "R7 hazard stall");
        drive(1, 2'b01, 32'd0, 16'h0040, 32'h0000_5004, 0, 1, 0, "R8 hold resolves current operand");
        drive(1, 2'b10, 32'd9, 16'h0040, 32'h0000_6004, 0, 1, 1, "R7 second hazard stalls again");
        drive(1, 2'b10, 32'd9, 16'h0040, 32'h0000_6004, 1, 0, 1, "R8 R6 hold resolve cancel mode");
        // R1: reset while holding
        drive(1, 2'b01, 32'd0, 16'h0040, 32'h0000_7004, 0, 1, 0, "R7 stall before reset");
        apply_reset();
        drive(1, 2'b01, 32'd0, 16'h0040, 32'h0000_7004, 0, 1, 0, "R1 reset clears hold state");
        drive(1, 2'b01, 32'd0, 16'h0040, 32'h0000_7004, 0, 1, 0, "R8 resolve after reset stall");
        idle("R4 idle tail");
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule